// File: doc/BRIEF.md
# Ring-Shared Block Node Merger

This block is one station on a one-way ring of nodes that keep passing a shared block of memory around the ring, one word at a time. Each word comes in from the upstream neighbour on a valid/ready handshake. The node holds a full local copy of every word it sees, and the local host can read that copy at any address. The word then goes to the downstream neighbour through a second valid/ready handshake. Because of this, the host sees the sections written by other nodes as a mailbox.

Each node owns one contiguous window of the block. The window is set by a base word address and a length in words. Only this node changes words inside its window, so two nodes never write the same word. The host posts a write into a pending store that keeps one valid bit per word. When the matching word next passes through the node, the pending value replaces it and the valid bit clears. A frame counter steps once for every complete pass of the block. The host can compare this count before and after a write to know when its change has gone out on the ring.

Top module: `ringnode_merger`

## Requirements
- R1: After reset the frame counter and the error flag are 0, the local copy reads 0 at every address, and the next accepted word is treated as word 0 of the block.
- R2: `dn_valid` follows `up_valid` and `up_ready` follows `dn_ready` in the same cycle. A word is transferred only in a cycle where both are high. A stalled cycle does not advance the word position.
- R3: A word whose position lies outside the window is forwarded with its incoming value.
- R4: A pending host value for a window position replaces the incoming word when that position is forwarded, in that one frame only. Later frames carry the incoming value again.
- R5: A position `a` is in the window when `cfg_base <= a` and `a < cfg_base + cfg_len`. A length of 0 gives an empty window, and host writes made then are never forwarded.
- R6: A host write to an address outside the window is discarded, so it changes no forwarded word. It sets `host_err`, which stays at 1 until reset.
- R7: Each transferred word is stored in the local copy at its position with the value that was forwarded. `host_rd_data` shows the copy at `host_rd_addr` in the same cycle.
- R8: The frame counter increments by one when the word at position FRAME_WORDS-1 is transferred. Position then wraps to 0, and the counter wraps at its width.
- R9: If a host write and the forwarding of the same window position fall in the same cycle, the forwarded word uses the value that was pending before (or the incoming value if none was pending). The new value stays pending for the next frame.
- R10: Repeated host writes to one window position before it is forwarded leave only the last value pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream word present |
| up_ready | output | 1 | Node accepts upstream word |
| up_data | input | 32 | Upstream word |
| dn_valid | output | 1 | Downstream word present |
| dn_ready | input | 1 | Downstream accepts word |
| dn_data | output | 32 | Merged word forwarded downstream |
| cfg_base | input | ADDR_W | First word of this node's window |
| cfg_len | input | ADDR_W+1 | Window length in words |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | ADDR_W | Host write word address |
| host_wr_data | input | 32 | Host write data |
| host_err | output | 1 | Sticky flag: write outside window seen |
| host_rd_addr | input | ADDR_W | Local copy read address |
| host_rd_data | output | 32 | Local copy word at read address |
| frame_count | output | CNT_W | Completed block passes |

## Verification
The hardest case to reach is a host write that lands in exactly the cycle in which the same window word is forwarded. Here the value that is already pending must go out, and the new value must survive into the next frame. The bench keeps its own count of the word position. It raises the host write strobe in the same low clock phase as the upstream word for that position, and checks the forwarded word in that cycle and in the following frame. Back-to-back writes to one word, an empty window and a stalled downstream side are also set up before frames are streamed.

// File: rtl/ringnode_pkg.sv
package ringnode_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/ringnode_window.sv
module ringnode_window #(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W:0]   len,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic [ADDR_W:0] offset;

    always_comb begin
        offset = {1'b0, addr} - {1'b0, base};
        hit    = (addr >= base) && (offset < len);
    end
endmodule

// File: rtl/ringnode_pending.sv
module ringnode_pending
    import ringnode_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int FRAME_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    input  logic              take,
    input  logic [ADDR_W-1:0] take_addr,
    output logic              hit_vld,
    output word_t             hit_data
);
    typedef struct packed {
        logic [FRAME_WORDS-1:0]             vld;
        logic [FRAME_WORDS-1:0][WORD_W-1:0] data;
    } pend_t;

    pend_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.vld[take_addr] = 1'b0;
        end
        if (wr_en) begin
            st_d.vld[wr_addr]  = 1'b1;
            st_d.data[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_vld  = st_q.vld[take_addr];
    assign hit_data = st_q.data[take_addr];

    // R4: a consumed entry is gone unless rewritten in the same cycle
    p_pending_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        take && !(wr_en && wr_addr == take_addr) |=> !st_q.vld[$past(take_addr)]);

    // R10: the most recent write is the one held
    p_last_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> st_q.vld[$past(wr_addr)] && st_q.data[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/ringnode_merger.sv
module ringnode_merger
    import ringnode_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int FRAME_WORDS = 16,
    parameter int CNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [31:0]       up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [31:0]       dn_data,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W:0]   cfg_len,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_wr_addr,
    input  logic [31:0]       host_wr_data,
    output logic              host_err,
    input  logic [ADDR_W-1:0] host_rd_addr,
    output logic [31:0]       host_rd_data,
    output logic [CNT_W-1:0]  frame_count
);
    localparam logic [ADDR_W-1:0] LAST_POS = ADDR_W'(FRAME_WORDS - 1);

    typedef struct packed {
        logic [ADDR_W-1:0]                  pos;
        logic [CNT_W-1:0]                   frames;
        logic                               err;
        logic [FRAME_WORDS-1:0][WORD_W-1:0] copy;
    } node_t;

    node_t st_d, st_q;

    logic  xfer, fwd_hit, host_hit, pend_vld;
    word_t pend_data, fwd_word;

    ringnode_window #(.ADDR_W(ADDR_W)) u_fwd_win (
        .base(cfg_base), .len(cfg_len), .addr(st_q.pos), .hit(fwd_hit)
    );

    ringnode_window #(.ADDR_W(ADDR_W)) u_host_win (
        .base(cfg_base), .len(cfg_len), .addr(host_wr_addr), .hit(host_hit)
    );

    ringnode_pending #(.ADDR_W(ADDR_W), .FRAME_WORDS(FRAME_WORDS)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr_en && host_hit),
        .wr_addr  (host_wr_addr),
        .wr_data  (host_wr_data),
        .take     (xfer && fwd_hit),
        .take_addr(st_q.pos),
        .hit_vld  (pend_vld),
        .hit_data (pend_data)
    );

    always_comb begin
        xfer     = up_valid && dn_ready;
        fwd_word = (fwd_hit && pend_vld) ? pend_data : up_data;
        st_d     = st_q;
        if (xfer) begin
            st_d.copy[st_q.pos] = fwd_word;
            if (st_q.pos == LAST_POS) begin
                st_d.pos    = '0;
                st_d.frames = st_q.frames + 1'b1;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
        if (host_wr_en && !host_hit) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up_ready     = dn_ready;
    assign dn_valid     = up_valid;
    assign dn_data      = fwd_word;
    assign host_err     = st_q.err;
    assign host_rd_data = st_q.copy[host_rd_addr];
    assign frame_count  = st_q.frames;

    // R2: a stalled word leaves the position where it was
    p_stall_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_valid && dn_ready) |=> $stable(st_q.pos));

    // R3: outside the window the word passes untouched
    p_outside_unchanged_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !fwd_hit |-> dn_data == up_data);

    // R6: an out-of-window write raises the flag
    p_bad_write_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr_en && !host_hit |=> host_err);

    // R7: local copy holds what was sent downstream
    p_copy_matches_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && dn_ready |=> st_q.copy[$past(st_q.pos)] == $past(dn_data));

    // R8: counter steps after the last word of a pass
    p_frame_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && dn_ready && st_q.pos == LAST_POS |=> frame_count == $past(frame_count) + 1'b1);
endmodule

// File: tb/ringnode_merger_test.sv
module ringnode_merger_test;
    localparam int AW = 3;
    localparam int FW = 8;
    localparam int CW = 8;

    localparam logic [31:0] VIN [FW] = '{
        32'h1000_0000, 32'h1000_0101, 32'h1000_0202, 32'h1000_0303,
        32'h1000_0404, 32'h1000_0505, 32'h1000_0606, 32'h1000_0707
    };
    localparam logic [31:0] VEXP [FW] = '{
        32'h1000_0000, 32'h1000_0101, 32'h1000_0202, 32'hA5A5_0003,
        32'h2222_2222, 32'h1000_0505, 32'h1000_0606, 32'h1000_0707
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_valid = 1'b0, up_ready, dn_valid, dn_ready = 1'b0, host_wr_en = 1'b0, host_err;
    logic [31:0] up_data = '0, dn_data, host_wr_data = '0, host_rd_data;
    logic [AW-1:0] cfg_base = '0, host_wr_addr = '0, host_rd_addr = '0;
    logic [AW:0] cfg_len = '0;
    logic [CW-1:0] frame_count;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ringnode_merger #(.ADDR_W(AW), .FRAME_WORDS(FW), .CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
        .cfg_base(cfg_base), .cfg_len(cfg_len),
        .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .host_err(host_err), .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
        .frame_count(frame_count)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_addr = a; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    // one word through the node; optional host write in the same cycle
    task automatic send_word(input logic [31:0] din, input logic [31:0] exp, input string tag,
                             input bit wr, input logic [AW-1:0] wa, input logic [31:0] wd);
        @(negedge clk);
        up_valid = 1'b1; up_data = din; dn_ready = 1'b1;
        host_wr_en = wr; host_wr_addr = wa; host_wr_data = wd;
        #2;
        check(dn_valid && dn_data == exp, tag, dn_data, exp);
        @(posedge clk);
        #1;
        up_valid = 1'b0; host_wr_en = 1'b0;
    endtask

    task automatic read_copy(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        host_rd_addr = a;
        #1;
        check(host_rd_data == exp, tag, host_rd_data, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(frame_count == 0, "R1 frame_count", 32'(frame_count), 0);
        check(host_err == 1'b0, "R1 host_err", 32'(host_err), 0);
        check(dn_valid == 1'b0, "R1 dn_valid", 32'(dn_valid), 0);
        read_copy(3'd5, 32'h0, "R1 copy zero");

        // window 2..4; R10 double write to word 4
        cfg_base = 3'd2; cfg_len = 4'd3;
        host_write(3'd3, 32'hA5A5_0003);
        host_write(3'd4, 32'h1111_1111);
        host_write(3'd4, 32'h2222_2222);
        #1 check(host_err == 1'b0, "R5 in-window writes no error", 32'(host_err), 0);
        host_write(3'd6, 32'hBAD0_0006);
        #1 check(host_err == 1'b1, "R6 outside write flags", 32'(host_err), 1);

        // R2 stall: downstream not ready
        @(negedge clk);
        up_valid = 1'b1; up_data = VIN[0]; dn_ready = 1'b0;
        #1;
        check(up_ready == 1'b0, "R2 up_ready follows dn_ready", 32'(up_ready), 0);
        check(dn_valid == 1'b1, "R2 dn_valid follows up_valid", 32'(dn_valid), 1);
        @(posedge clk);
        #1 up_valid = 1'b0;

        // frame 1: vector table walk (R3, R4, R10; position 0 after stall checks R2)
        for (int i = 0; i < FW; i++)
            send_word(VIN[i], VEXP[i], $sformatf("R3/R4 frame1 word %0d", i), 1'b0, '0, '0);
        #1 check(frame_count == 1, "R8 count after frame1", 32'(frame_count), 1);
        read_copy(3'd3, 32'hA5A5_0003, "R7 copy holds merged word");
        read_copy(3'd0, VIN[0], "R7 copy holds passed word");
        read_copy(3'd6, VIN[6], "R6 ignored write not in copy");

        // frame 2: pending consumed, all pass through (R4)
        for (int i = 0; i < FW; i++)
            send_word(VIN[i], VIN[i], $sformatf("R4 frame2 word %0d", i), 1'b0, '0, '0);
        #1 check(frame_count == 2, "R8 count after frame2", 32'(frame_count), 2);

        // R5 empty window: write never forwarded
        cfg_len = '0;
        host_write(3'd2, 32'hCAFE_0002);
        for (int i = 0; i < FW; i++)
            send_word(VIN[i], VIN[i], $sformatf("R5 empty window word %0d", i), 1'b0, '0, '0);

        // R9 collision: write word 3 while word 3 is forwarded
        cfg_base = '0; cfg_len = 4'd8;
        for (int i = 0; i < FW; i++)
            send_word(VIN[i], VIN[i], $sformatf("R9 collision frame word %0d", i),
                      i == 3, 3'd3, 32'hDEAD_0003);
        for (int i = 0; i < FW; i++)
            send_word(VIN[i], (i == 3) ? 32'hDEAD_0003 : VIN[i],
                      $sformatf("R9 next frame word %0d", i), 1'b0, '0, '0);
        #1 check(frame_count == 5, "R8 count after frame5", 32'(frame_count), 5);
        read_copy(3'd3, 32'hDEAD_0003, "R7 copy after collision");

        finish_run();
    end
endmodule